// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a simple synchronous host port and an external asynchronous static RAM of 512K words by 8 bits. The host presents one read or one write at a time with a request pulse. The controller turns each request into a timed sequence on the memory's active-low select, write and output-enable lines. It holds the address and the write data steady for the whole access, and for a read it registers the returned byte and presents it for one cycle.

The memory's minimum times are parameters in nanoseconds, together with the clock period. At elaboration they are rounded up to whole clock cycles, and every phase lasts at least one cycle. The shared data lines are split at this block's edge into an outgoing value, a driver enable and an incoming value. The controller turns its drivers on only inside the write strobe, and only once the memory has had time to release the bus after its outputs were last enabled.

Top module: `asram_ctl`

## Requirements
- R1: While reset is held and whenever no access is in progress, `memCsN`, `memWeN` and `memOeN` are 1, `memDqOutEn` is 0, `rvalid` is 0 and `ready` is 1.
- R2: A request is taken only on a clock edge where `req` and `ready` are both 1. `ready` is 0 from the cycle after that edge until the access has finished.
- R3: A read (`we`=0) holds `memCsN`=0, `memOeN`=0 and `memWeN`=1 for RD_CYC consecutive cycles. RD_CYC is the largest of the rounded-up address access time (55 ns), read cycle time (55 ns) and output-enable access time (25 ns), which gives 6 at a 10 ns clock.
- R4: A write (`we`=1) holds `memCsN` and `memWeN` low together for WR_CYC consecutive cycles. WR_CYC is the largest of the rounded-up write pulse (40 ns), write cycle (55 ns), address-to-strobe-end (50 ns) and data setup (25 ns) times, which gives 6 at a 10 ns clock. `memOeN` stays 1 for the whole write.
- R5: `memDqOutEn` is 1 only while `memCsN`=0, `memWeN`=0 and `memOeN`=1. While it is 1, `memDqOut` carries the `wdata` taken with the request, so the byte stored at `addr` is that value.
- R6: `memDqOutEn` rises only after `memOeN` has been 1 for at least TURN_CYC full cycles, where TURN_CYC is the rounded-up output release time (20 ns, so 2 cycles). When a write is requested in the first idle cycle after a read, the drivers turn on exactly TURN_CYC cycles after `memOeN` rises.
- R7: `memAddr` takes `addr` at the accepting edge, is set up at least one cycle before `memWeN` falls, and does not change while `memCsN` is 0.
- R8: `memOeN` and `memWeN` are never 0 in the same cycle.
- R9: The memory byte is sampled on the last cycle of the read strobe. `rdata` holds it and `rvalid` is 1 for exactly one cycle, the cycle right after the strobes rise.
- R10: A `req` raised while `ready` is 0 is ignored: it starts no access and changes no memory location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, taken when `ready` is 1 |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Host word address |
| wdata | input | 8 | Host write byte |
| ready | output | 1 | Controller idle and able to take a request |
| rvalid | output | 1 | One-cycle pulse that marks `rdata` valid |
| rdata | output | 8 | Byte returned by the last read |
| memAddr | output | 19 | Address lines to the memory |
| memCsN | output | 1 | Active-low chip select |
| memWeN | output | 1 | Active-low write enable |
| memOeN | output | 1 | Active-low output enable |
| memDqOut | output | 8 | Byte the controller drives onto the data lines |
| memDqOutEn | output | 1 | Enable for the controller's data drivers |
| memDqIn | input | 8 | Resolved value of the data lines |

## Verification
The bench's memory model drives data only after a full access time, and it keeps its outputs on for part of the release time after output enable rises. A controller that shortens the read strobe captures junk, and one that drives early in a read-then-write pair collides with the model on the bus. Write strobes shorter than the minimum are not stored, so the read-back fails, and an address that moves under the strobe is flagged. A request made while busy is followed by a read of its target and a count of select falls, which catches a controller that queues or starts the stray access.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE
  } ctlState_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic selN;     // chip select, active low
    logic writeN;   // write enable, active low
    logic outEnN;   // output enable, active low
    logic drive;    // turn on the controller's data drivers
    logic load;     // take address and write byte from the host
    logic capture;  // register the byte on the data lines
  } memStrobe_t;

  // Round a minimum time up to whole cycles, never below one.
  function automatic int nsToCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctl_fsm.sv
module asram_ctl_fsm
  import asram_pkg::*;
#(
  parameter int RD_CYC = 6,
  parameter int WR_CYC = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       req,
  input  logic       we,
  input  logic       turnClear,
  output logic       ready,
  output memStrobe_t stb
);

  localparam int CNT_MAX = maxOf(RD_CYC, WR_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  ctlState_e        stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic             lastBeat;

  assign lastBeat = (cntQ == '0);

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (req) begin
          if (we) begin
            stateD = ST_WSETUP;
          end else begin
            stateD = ST_READ;
            cntD   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (lastBeat) stateD = ST_IDLE;
        else          cntD   = cntQ - 1'b1;
      end
      ST_WSETUP: begin
        if (turnClear) begin
          stateD = ST_WPULSE;
          cntD   = CNT_W'(WR_CYC - 1);
        end
      end
      ST_WPULSE: begin
        if (lastBeat) stateD = ST_IDLE;
        else          cntD   = cntQ - 1'b1;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  assign ready = (stateQ == ST_IDLE);

  always_comb begin
    stb.selN    = !((stateQ == ST_READ) || (stateQ == ST_WPULSE));
    stb.writeN  = (stateQ != ST_WPULSE);
    stb.outEnN  = (stateQ != ST_READ);
    stb.drive   = (stateQ == ST_WPULSE);
    stb.load    = (stateQ == ST_IDLE) && req;
    stb.capture = (stateQ == ST_READ) && lastBeat;
  end

endmodule

// File: rtl/asram_ctl_dp.sv
module asram_ctl_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int TURN_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              turnClear,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOutEn
);

  localparam int Q_W = $clog2(TURN_CYC + 1);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              rvalidQ;
  logic [Q_W-1:0]    quietQ;   // full cycles since output enable was last low

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      rdataQ  <= '0;
      rvalidQ <= 1'b0;
      quietQ  <= Q_W'(TURN_CYC);
    end else begin
      if (stb.load) begin
        addrQ  <= addr;
        wdataQ <= wdata;
      end
      if (stb.capture) rdataQ <= memDqIn;
      rvalidQ <= stb.capture;
      if (!stb.outEnN)                  quietQ <= '0;
      else if (quietQ < Q_W'(TURN_CYC)) quietQ <= quietQ + 1'b1;
    end
  end

  // The next cycle has a full release time behind it once this holds.
  assign turnClear  = (quietQ >= Q_W'(TURN_CYC - 1));

  assign rvalid     = rvalidQ;
  assign rdata      = rdataQ;
  assign memAddr    = addrQ;
  assign memCsN     = stb.selN;
  assign memWeN     = stb.writeN;
  assign memOeN     = stb.outEnN;
  assign memDqOut   = wdataQ;
  assign memDqOutEn = stb.drive;

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_AACC_NS = 55,
  parameter int T_RCYC_NS = 55,
  parameter int T_OACC_NS = 25,
  parameter int T_WPUL_NS = 40,
  parameter int T_WCYC_NS = 55,
  parameter int T_AWE_NS  = 50,
  parameter int T_DSU_NS  = 25,
  parameter int T_REL_NS  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOutEn,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int RD_CYC = maxOf(maxOf(nsToCycles(T_AACC_NS, CLK_NS),
                                      nsToCycles(T_RCYC_NS, CLK_NS)),
                                nsToCycles(T_OACC_NS, CLK_NS));
  localparam int WR_CYC = maxOf(maxOf(nsToCycles(T_WPUL_NS, CLK_NS),
                                      nsToCycles(T_WCYC_NS, CLK_NS)),
                                maxOf(nsToCycles(T_AWE_NS, CLK_NS),
                                      nsToCycles(T_DSU_NS, CLK_NS)));
  localparam int TURN_CYC = nsToCycles(T_REL_NS, CLK_NS);

  memStrobe_t stb;
  logic       turnClear;

  asram_ctl_fsm #(
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC)
  ) u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .req       (req),
    .we        (we),
    .turnClear (turnClear),
    .ready     (ready),
    .stb       (stb)
  );

  asram_ctl_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TURN_CYC (TURN_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .addr       (addr),
    .wdata      (wdata),
    .memDqIn    (memDqIn),
    .turnClear  (turnClear),
    .rvalid     (rvalid),
    .rdata      (rdata),
    .memAddr    (memAddr),
    .memCsN     (memCsN),
    .memWeN     (memWeN),
    .memOeN     (memOeN),
    .memDqOut   (memDqOut),
    .memDqOutEn (memDqOutEn)
  );

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk #(
  parameter int ADDR_W   = 19,
  parameter int RD_CYC   = 6,
  parameter int WR_CYC   = 6,
  parameter int TURN_CYC = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              req,
  input logic              ready,
  input logic              rvalid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCsN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDqOutEn
);

  logic [15:0] oeRunQ, weRunQ, quietQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oeRunQ <= '0;
      weRunQ <= '0;
      quietQ <= 16'(TURN_CYC);
    end else begin
      oeRunQ <= memOeN ? 16'd0 : oeRunQ + 16'd1;
      weRunQ <= memWeN ? 16'd0 : weRunQ + 16'd1;
      if (!memOeN)                     quietQ <= '0;
      else if (quietQ < 16'(TURN_CYC)) quietQ <= quietQ + 16'd1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (memCsN && memWeN && memOeN && !memDqOutEn));

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rstN)
    (req && ready) |=> !ready);

  assert_read_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> (oeRunQ == 16'(RD_CYC)));

  assert_write_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weRunQ == 16'(WR_CYC)));

  assert_drive_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    memDqOutEn |-> (!memCsN && !memWeN && memOeN));

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rstN)
    memDqOutEn |-> (quietQ >= 16'(TURN_CYC)));

  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && !$past(memCsN)) |-> $stable(memAddr));

  assert_no_oe_we_overlap_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  assert_rvalid_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rvalid |=> !rvalid);

endmodule

bind asram_ctl asram_ctl_chk #(
  .ADDR_W   (ADDR_W),
  .RD_CYC   (RD_CYC),
  .WR_CYC   (WR_CYC),
  .TURN_CYC (TURN_CYC)
) u_chk (.*);

// File: tb/asram_ctl_bench.sv
module asram_ctl_bench;

  localparam int CLK_NS  = 10;
  localparam int B_RD    = (55 + CLK_NS - 1) / CLK_NS;  // read strobe cycles
  localparam int B_WR    = (55 + CLK_NS - 1) / CLK_NS;  // write strobe cycles
  localparam int B_TURN  = (20 + CLK_NS - 1) / CLK_NS;  // release cycles
  localparam int HOLD_NE = 2;                          // model drive tail, negedges

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, rvalid;
  logic [7:0]  rdata;
  logic [18:0] memAddr;
  logic        memCsN, memWeN, memOeN, memDqOutEn;
  logic [7:0]  memDqOut, memDqIn;

  always #5 clk = ~clk;

  asram_ctl u_asram_ctl (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rvalid(rvalid), .rdata(rdata), .memAddr(memAddr),
    .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN), .memDqOut(memDqOut),
    .memDqOutEn(memDqOutEn), .memDqIn(memDqIn)
  );

  // ---------------- behavioural memory model (negedge sampled) -------------
  logic [7:0] mem [256];
  int  accCnt = 0, holdCnt = 0, wrRun = 0;
  int  violations = 0, conflicts = 0;
  logic [7:0]  wrByte;
  logic [18:0] wrAddr;
  logic modelActive, modelDrive;
  logic [7:0] modelData;

  assign modelActive = !memCsN && !memOeN && memWeN;
  assign modelDrive  = modelActive || (holdCnt > 0);
  assign modelData   = (modelActive && accCnt >= B_RD) ? mem[memAddr[7:0]] : 8'hE7;
  assign memDqIn     = memDqOutEn ? memDqOut : (modelDrive ? modelData : 8'h5A);

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  always @(negedge clk) begin
    if (memDqOutEn && modelDrive) conflicts++;
    if (!memOeN && !memWeN) violations++;
    if (modelActive) begin
      accCnt  <= accCnt + 1;
      holdCnt <= HOLD_NE;
    end else begin
      accCnt <= 0;
      if (holdCnt > 0) holdCnt <= holdCnt - 1;
    end
    if (!memCsN && !memWeN) begin
      if (wrRun > 0 && memAddr != wrAddr) violations++;
      if (!memOeN) violations++;
      wrRun  <= wrRun + 1;
      wrByte <= memDqIn;
      wrAddr <= memAddr;
    end else if (wrRun > 0) begin
      if (wrRun >= B_WR) mem[wrAddr[7:0]] <= wrByte;
      else violations++;
      wrRun <= 0;
    end
  end

  // ---------------- observation monitor ------------------------------------
  int oeRun = 0, weRun = 0, lastOeRun = 0, lastWeRun = 0;
  int sinceOe = 100, gapSeen = -1, csFalls = 0, rvCount = 0;
  logic prevCsN = 1'b1, prevDrv = 1'b0;

  always @(negedge clk) begin
    if (!memOeN) begin oeRun <= oeRun + 1; sinceOe <= 0; end
    else begin
      if (oeRun > 0) lastOeRun <= oeRun;
      oeRun <= 0;
      if (sinceOe < 100) sinceOe <= sinceOe + 1;
    end
    if (!memWeN) weRun <= weRun + 1;
    else begin
      if (weRun > 0) lastWeRun <= weRun;
      weRun <= 0;
    end
    if (memDqOutEn && !prevDrv) gapSeen <= sinceOe;
    if (prevCsN && !memCsN) csFalls <= csFalls + 1;
    if (rvalid) rvCount <= rvCount + 1;
    prevCsN <= memCsN;
    prevDrv <= memDqOutEn;
  end

  // ---------------- checking helpers ---------------------------------------
  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called and returns on a negedge with ready high.
  task automatic doOp(input logic w, input logic [18:0] a, input logic [7:0] d,
                      output logic [7:0] r);
    while (!ready) @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    r = 8'h00;
    if (!w) begin
      while (!rvalid) @(negedge clk);
      r = rdata;
    end else begin
      while (!ready) @(negedge clk);
    end
  endtask

  // {we, addr[7:0], data[7:0]}; for reads data is the expected byte
  localparam logic [16:0] VEC [9] = '{
    {1'b1, 8'h10, 8'hA5}, {1'b1, 8'h11, 8'h3C}, {1'b0, 8'h10, 8'hA5},
    {1'b0, 8'h11, 8'h3C}, {1'b1, 8'h10, 8'hFF}, {1'b0, 8'h10, 8'hFF},
    {1'b1, 8'hFF, 8'h01}, {1'b0, 8'hFF, 8'h01}, {1'b0, 8'h00, 8'h00}
  };

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] got;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R1 ready in reset", ready, 1);
    check({memCsN, memWeN, memOeN} == 3'b111, "R1 strobes in reset", {memCsN, memWeN, memOeN}, 7);
    check(!memDqOutEn && !rvalid, "R1 drive/rvalid in reset", {memDqOutEn, rvalid}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check({memCsN, memWeN, memOeN} == 3'b111, "R1 strobes idle", {memCsN, memWeN, memOeN}, 7);

    // Table walk: R3, R4, R5, R9 under several patterns
    foreach (VEC[i]) begin
      int rv0;
      rv0 = rvCount;
      doOp(VEC[i][16], {11'h0, VEC[i][15:8]}, VEC[i][7:0], got);
      @(negedge clk);
      if (VEC[i][16]) begin
        check(lastWeRun == B_WR, "R4 write strobe length", lastWeRun, B_WR);
      end else begin
        check(got == VEC[i][7:0], "R5 R9 read data", got, VEC[i][7:0]);
        check(lastOeRun == B_RD, "R3 read strobe length", lastOeRun, B_RD);
        check(rvCount - rv0 == 1, "R9 single rvalid", rvCount - rv0, 1);
      end
    end

    // R6: write taken in the first idle cycle after a read
    doOp(1'b0, 19'h10, 8'h00, got);
    doOp(1'b1, 19'h40, 8'hC3, got);
    @(negedge clk);
    check(gapSeen == B_TURN, "R6 turnaround after read", gapSeen, B_TURN);
    doOp(1'b0, 19'h40, 8'h00, got);
    check(got == 8'hC3, "R6 data after turnaround", got, 8'hC3);

    // R6: write after write, drivers wait no more than needed
    doOp(1'b1, 19'h41, 8'h11, got);
    doOp(1'b1, 19'h42, 8'h22, got);
    doOp(1'b0, 19'h42, 8'h00, got);
    check(got == 8'h22, "R6 back-to-back write", got, 8'h22);

    // R7: high address bits reach the pins and stay put
    doOp(1'b1, 19'h7FF33, 8'h9D, got);
    check(memAddr == 19'h7FF33, "R7 address held", memAddr, 19'h7FF33);

    // R2 R10: request while busy is ignored
    begin
      int cs0;
      cs0 = csFalls;
      while (!ready) @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 19'h20; wdata = 8'h77;
      @(negedge clk);
      check(ready == 1'b0, "R2 busy after take", ready, 0);
      addr = 19'h21; wdata = 8'h99;
      repeat (3) @(negedge clk);
      req = 1'b0;
      while (!ready) @(negedge clk);
      @(negedge clk);
      check(csFalls - cs0 == 1, "R10 one access only", csFalls - cs0, 1);
    end
    doOp(1'b0, 19'h21, 8'h00, got);
    check(got == 8'h00, "R10 ignored write not stored", got, 0);
    doOp(1'b0, 19'h20, 8'h00, got);
    check(got == 8'h77, "R2 taken write stored", got, 8'h77);

    @(negedge clk);
    check({memCsN, memWeN, memOeN, memDqOutEn} == 4'b1110, "R1 idle after traffic",
          {memCsN, memWeN, memOeN, memDqOutEn}, 4'he);
    check(violations == 0, "R4 R7 R8 model timing", violations, 0);
    check(conflicts == 0, "R6 bus conflicts", conflicts, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule